// File: doc/BRIEF.md
# Event-Triggered Delay and Pulse Channel

This block is a single output channel of a timing receiver. Every decoded 32-bit frame that arrives with a valid strobe is compared with a programmed trigger word, using a per-bit mask so that chosen bits can be ignored. When a frame hits, the channel loads a delay counter and waits for its start condition. It then counts ticks from a selected clock source. When the count runs out, the channel drives an output pulse of programmed width, raises an interrupt request, or does both.

There are three repetition modes. A one-shot channel fires once. A multi-pulse channel reloads the delay after each pulse until a programmed number of pulses has been sent. A burst channel keeps repeating until an external stop edge arrives. The start source and the count clock are chosen independently. Each can be the previous channel in a chain, an external pin, or, for the start, the triggering frame itself; for the clock, the block's own base clock. External pins are resynchronised before use. All configuration arrives as static register inputs.

Top module: `trig_delay_chan`

## Requirements
- R1: A frame hits only when `cfg_enable` is 1, `frame_valid` is 1, and `frame_data` equals `cfg_match_word` on every bit where `cfg_match_mask` is 1. Bits where the mask is 0 are ignored, so an all-zero mask matches every frame.
- R2: With event start (`cfg_start_sel`=0) and base clock (`cfg_clk_sel`=0), take a hitting frame sampled at edge k and a delay D. `pulse_out` becomes active after edge k+2+D.
- R3: A delay of 0 fires on the first clock tick after the start condition.
- R4: The active level lasts `cfg_width` base-clock cycles. A width of 0 is treated as 1.
- R5: In once mode (`cfg_mode`=0, and also 3), the channel emits one pulse and then returns to idle.
- R6: In multi-pulse mode (`cfg_mode`=1), the channel emits `cfg_pulses` pulses, with 0 treated as 1. Successive pulse starts are D+1+W cycles apart.
- R7: In burst mode (`cfg_mode`=2), pulses repeat with period D+1+W until a rising edge on `ext_stop`. The current pulse then completes and no further pulse follows. In the other modes `ext_stop` has no effect.
- R8: For start selection, 1 means `chain_in` and 2 means `ext_start`. The delay is loaded at the hit, and counting waits for the start edge. The first base tick follows 2 cycles after a `chain_in` rise and 3 cycles after an `ext_start` rise (two-flop synchroniser), both counted from the edge that samples the rise.
- R9: For clock selection, 1 means each `chain_in` rise is one tick and 2 means each `ext_clk` rise is one tick. D+1 ticks are needed to fire. The pulse starts after the sampling edge plus 1 cycle for `chain_in`, or plus 2 cycles for `ext_clk`.
- R10: A hit that arrives while the channel is not idle is ignored and does not disturb the pulse train. It sets the sticky `overrun` flag, which is cleared only by reset.
- R11: `pulse_out` equals `cfg_invert` XOR (`cfg_act_out` AND active). `irq` is high for exactly one cycle, coinciding with the first active cycle of each pulse, and only when `cfg_act_irq` is 1.
- R12: After reset, `pulse_out`, `irq` and `overrun` are 0 and the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Frame strobe |
| frame_data | input | FRAME_W | Decoded frame |
| cfg_enable | input | 1 | Channel enable for triggering |
| cfg_match_word | input | FRAME_W | Trigger word |
| cfg_match_mask | input | FRAME_W | 1 = bit compared |
| cfg_start_sel | input | 2 | 0 event, 1 chain, 2 external |
| cfg_clk_sel | input | 2 | 0 base, 1 chain, 2 external |
| cfg_mode | input | 2 | 0 once, 1 multi, 2 burst |
| cfg_delay | input | DLY_W | Delay in ticks |
| cfg_width | input | WID_W | Pulse width in base cycles |
| cfg_pulses | input | PCNT_W | Pulse count for multi mode |
| cfg_act_out | input | 1 | Drive output on expiry |
| cfg_act_irq | input | 1 | Raise interrupt on expiry |
| cfg_invert | input | 1 | Output polarity inversion |
| chain_in | input | 1 | Previous channel output, synchronous |
| ext_start | input | 1 | Asynchronous external start |
| ext_clk | input | 1 | Asynchronous external count clock |
| ext_stop | input | 1 | Asynchronous burst stop |
| pulse_out | output | 1 | Registered channel output |
| irq | output | 1 | One-cycle interrupt request |
| overrun | output | 1 | Sticky ignored-hit flag |

## Verification
The bench builds the channel with an 8-bit delay, a 3-bit width and a 2-bit pulse count. With these sizes, every width including the zero case can be swept, and so can every pulse count. Delays from 0 upward can be swept together with them, and the largest delay of 255 can be reached in a few hundred cycles. Each output and interrupt cycle is compared against a closed-form schedule built from the start latency, D and W. This covers every mode and every start and clock source, as well as the mask, enable, stop and overrun cases.

// File: rtl/trig_delay_chan_pkg.sv
package trig_delay_chan_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_COUNT = 2'd2,
    CH_PULSE = 2'd3
  } chan_state_e;

  localparam logic [1:0] START_EVENT = 2'd0;
  localparam logic [1:0] START_CHAIN = 2'd1;
  localparam logic [1:0] START_EXT   = 2'd2;

  localparam logic [1:0] TICK_BASE  = 2'd0;
  localparam logic [1:0] TICK_CHAIN = 2'd1;
  localparam logic [1:0] TICK_EXT   = 2'd2;

  localparam logic [1:0] MODE_ONCE  = 2'd0;
  localparam logic [1:0] MODE_MULTI = 2'd1;
  localparam logic [1:0] MODE_BURST = 2'd2;
endpackage

// File: rtl/trig_delay_chan_match.sv
module trig_delay_chan_match #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic [FRAME_W-1:0] data,
  input  logic [FRAME_W-1:0] word,
  input  logic [FRAME_W-1:0] mask,
  input  logic               enable,
  output logic               hit
);
  logic [FRAME_W-1:0] diff;
  logic               hit_q;

  assign diff = (data ^ word) & mask;

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= valid && enable && (diff == '0);
  end

  assign hit = hit_q;
endmodule

// File: rtl/trig_delay_chan_edge.sv
module trig_delay_chan_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int TOP = (STAGES < 1) ? 1 : STAGES;
  logic [TOP:0] sh_q;

  generate
    if (TOP == 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[0], din};
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[TOP-1:0], din};
      end
    end
  endgenerate

  assign rise = sh_q[TOP-1] & ~sh_q[TOP];
endmodule

// File: rtl/trig_delay_chan_seq.sv
module trig_delay_chan_seq
  import trig_delay_chan_pkg::*;
#(
  parameter int DLY_W  = 22,
  parameter int WID_W  = 16,
  parameter int PCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              start_is_event,
  input  logic              start_rise,
  input  logic              tick,
  input  logic              stop_rise,
  input  logic [1:0]        mode,
  input  logic [DLY_W-1:0]  delay,
  input  logic [WID_W-1:0]  width,
  input  logic [PCNT_W-1:0] pulses,
  input  logic              act_out,
  input  logic              act_irq,
  input  logic              invert,
  output logic              pulse_out,
  output logic              irq,
  output logic              overrun
);
  localparam logic [PCNT_W-1:0] ONE_PULSE = PCNT_W'(1);

  chan_state_e       state_q, state_n;
  logic [DLY_W-1:0]  cnt_q, cnt_n;
  logic [WID_W-1:0]  wleft_q, wleft_n;
  logic [PCNT_W-1:0] left_q, left_n;
  logic              stop_q, stop_n;
  logic              fire;
  logic              out_q, irq_q, ovr_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    wleft_n = wleft_q;
    left_n  = left_q;
    stop_n  = stop_q;
    fire    = 1'b0;
    case (state_q)
      CH_IDLE: begin
        if (hit) begin
          cnt_n   = delay;
          left_n  = (pulses == '0) ? ONE_PULSE : pulses;
          stop_n  = 1'b0;
          state_n = start_is_event ? CH_COUNT : CH_ARMED;
        end
      end
      CH_ARMED: begin
        if (start_rise) state_n = CH_COUNT;
      end
      CH_COUNT: begin
        if (tick) begin
          if (cnt_q == '0) begin
            fire    = 1'b1;
            state_n = CH_PULSE;
            wleft_n = (width == '0) ? '0 : width - WID_W'(1);
          end else begin
            cnt_n = cnt_q - DLY_W'(1);
          end
        end
      end
      default: begin
        if (wleft_q == '0) begin
          case (mode)
            MODE_MULTI: begin
              if (left_q <= ONE_PULSE) state_n = CH_IDLE;
              else begin
                left_n  = left_q - ONE_PULSE;
                cnt_n   = delay;
                state_n = CH_COUNT;
              end
            end
            MODE_BURST: begin
              if (stop_q || stop_rise) state_n = CH_IDLE;
              else begin
                cnt_n   = delay;
                state_n = CH_COUNT;
              end
            end
            default: state_n = CH_IDLE;
          endcase
        end else begin
          wleft_n = wleft_q - WID_W'(1);
        end
      end
    endcase
    if (state_q != CH_IDLE && stop_rise) stop_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
      wleft_q <= '0;
      left_q  <= '0;
      stop_q  <= 1'b0;
      out_q   <= 1'b0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      wleft_q <= wleft_n;
      left_q  <= left_n;
      stop_q  <= stop_n;
      out_q   <= invert ^ (act_out && (state_n == CH_PULSE));
      irq_q   <= act_irq && fire;
      ovr_q   <= ovr_q || (hit && (state_q != CH_IDLE));
    end
  end

  assign pulse_out = out_q;
  assign irq       = irq_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/trig_delay_chan.sv
module trig_delay_chan
  import trig_delay_chan_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int DLY_W   = 22,
  parameter int WID_W   = 16,
  parameter int PCNT_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               cfg_enable,
  input  logic [FRAME_W-1:0] cfg_match_word,
  input  logic [FRAME_W-1:0] cfg_match_mask,
  input  logic [1:0]         cfg_start_sel,
  input  logic [1:0]         cfg_clk_sel,
  input  logic [1:0]         cfg_mode,
  input  logic [DLY_W-1:0]   cfg_delay,
  input  logic [WID_W-1:0]   cfg_width,
  input  logic [PCNT_W-1:0]  cfg_pulses,
  input  logic               cfg_act_out,
  input  logic               cfg_act_irq,
  input  logic               cfg_invert,
  input  logic               chain_in,
  input  logic               ext_start,
  input  logic               ext_clk,
  input  logic               ext_stop,
  output logic               pulse_out,
  output logic               irq,
  output logic               overrun
);
  logic hit;
  logic chain_rise, xstart_rise, xclk_rise, xstop_rise;
  logic start_rise, start_is_event, tick;

  trig_delay_chan_match #(.FRAME_W(FRAME_W)) u_match (
    .clk(clk), .rst(rst), .valid(frame_valid), .data(frame_data),
    .word(cfg_match_word), .mask(cfg_match_mask), .enable(cfg_enable),
    .hit(hit)
  );

  trig_delay_chan_edge #(.STAGES(1)) u_chain_edge (
    .clk(clk), .rst(rst), .din(chain_in), .rise(chain_rise)
  );
  trig_delay_chan_edge #(.STAGES(SYNC_N)) u_start_edge (
    .clk(clk), .rst(rst), .din(ext_start), .rise(xstart_rise)
  );
  trig_delay_chan_edge #(.STAGES(SYNC_N)) u_clk_edge (
    .clk(clk), .rst(rst), .din(ext_clk), .rise(xclk_rise)
  );
  trig_delay_chan_edge #(.STAGES(SYNC_N)) u_stop_edge (
    .clk(clk), .rst(rst), .din(ext_stop), .rise(xstop_rise)
  );

  always_comb begin
    start_is_event = 1'b0;
    start_rise     = 1'b0;
    case (cfg_start_sel)
      START_CHAIN: start_rise = chain_rise;
      START_EXT:   start_rise = xstart_rise;
      default:     start_is_event = 1'b1;
    endcase
    case (cfg_clk_sel)
      TICK_CHAIN: tick = chain_rise;
      TICK_EXT:   tick = xclk_rise;
      default:    tick = 1'b1;
    endcase
  end

  trig_delay_chan_seq #(.DLY_W(DLY_W), .WID_W(WID_W), .PCNT_W(PCNT_W)) u_seq (
    .clk(clk), .rst(rst), .hit(hit),
    .start_is_event(start_is_event), .start_rise(start_rise),
    .tick(tick), .stop_rise(xstop_rise), .mode(cfg_mode),
    .delay(cfg_delay), .width(cfg_width), .pulses(cfg_pulses),
    .act_out(cfg_act_out), .act_irq(cfg_act_irq), .invert(cfg_invert),
    .pulse_out(pulse_out), .irq(irq), .overrun(overrun)
  );
endmodule

// File: rtl/trig_delay_chan_chk.sv
module trig_delay_chan_chk (
  input logic clk,
  input logic rst,
  input logic cfg_act_out,
  input logic cfg_act_irq,
  input logic cfg_invert,
  input logic pulse_out,
  input logic irq,
  input logic overrun
);
  // R11: an interrupt needs the interrupt action enabled
  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(cfg_act_irq));

  // R11: an interrupt lasts one cycle (period is at least two cycles)
  assert_irq_single_R11: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R11: interrupt coincides with the active output level
  assert_irq_with_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pulse_out == ($past(cfg_invert) ^ $past(cfg_act_out))));

  // R11: with output action off the pin sits at the polarity level
  assert_quiet_level_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_act_out)) |-> (pulse_out == $past(cfg_invert)));

  // R10: overrun is sticky
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind trig_delay_chan trig_delay_chan_chk u_chk (
  .clk(clk), .rst(rst), .cfg_act_out(cfg_act_out), .cfg_act_irq(cfg_act_irq),
  .cfg_invert(cfg_invert), .pulse_out(pulse_out), .irq(irq), .overrun(overrun)
);

// File: tb/trig_delay_chan_tb.sv
module trig_delay_chan_tb_top;
  localparam int FW = 32;
  localparam int DW = 8;
  localparam int WW = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_valid = 1'b0;
  logic [FW-1:0] frame_data = '0;
  logic cfg_enable = 1'b1;
  logic [FW-1:0] cfg_match_word = 32'h1234_5678;
  logic [FW-1:0] cfg_match_mask = 32'hFFFF_FFFF;
  logic [1:0] cfg_start_sel = 2'd0, cfg_clk_sel = 2'd0, cfg_mode = 2'd0;
  logic [DW-1:0] cfg_delay = '0;
  logic [WW-1:0] cfg_width = 3'd1;
  logic [PW-1:0] cfg_pulses = 2'd1;
  logic cfg_act_out = 1'b1, cfg_act_irq = 1'b1, cfg_invert = 1'b0;
  logic chain_in = 1'b0, ext_start = 1'b0, ext_clk = 1'b0, ext_stop = 1'b0;
  logic pulse_out, irq, overrun;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trig_delay_chan #(.FRAME_W(FW), .DLY_W(DW), .WID_W(WW), .PCNT_W(PW), .SYNC_N(2)) dut_i (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
    .cfg_enable(cfg_enable), .cfg_match_word(cfg_match_word), .cfg_match_mask(cfg_match_mask),
    .cfg_start_sel(cfg_start_sel), .cfg_clk_sel(cfg_clk_sel), .cfg_mode(cfg_mode),
    .cfg_delay(cfg_delay), .cfg_width(cfg_width), .cfg_pulses(cfg_pulses),
    .cfg_act_out(cfg_act_out), .cfg_act_irq(cfg_act_irq), .cfg_invert(cfg_invert),
    .chain_in(chain_in), .ext_start(ext_start), .ext_clk(ext_clk), .ext_stop(ext_stop),
    .pulse_out(pulse_out), .irq(irq), .overrun(overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pulse j active for t in [t0+j*p, t0+j*p+w)
  function automatic bit exp_on(int t, int t0, int p, int w, int n);
    for (int j = 0; j < n; j++) begin
      if (t0 + j*p > t) return 1'b0;
      if (t < t0 + j*p + w) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit exp_irq(int t, int t0, int p, int n);
    for (int j = 0; j < n; j++) if (t == t0 + j*p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_evt(input string tag, input int d, input int w, input int n,
                         input logic [1:0] mode, input bit aout, input bit airq, input bit inv,
                         input logic [31:0] fr, input bit trig, input int tlen,
                         input int second_at, input int stop_at);
    int we, ne, p, t0, tend;
    we = (w == 0) ? 1 : w;
    ne = (mode == 2'd2) ? 1000 : ((mode == 2'd1) ? ((n == 0) ? 1 : n) : 1);
    p  = d + 1 + we;
    t0 = 2 + d;
    tend = (tlen > 0) ? tlen : (trig ? t0 + ne*p + 3 : 24);
    @(negedge clk);
    cfg_delay = DW'(d); cfg_width = WW'(w); cfg_pulses = PW'(n); cfg_mode = mode;
    cfg_act_out = aout; cfg_act_irq = airq; cfg_invert = inv;
    frame_valid = 1'b1; frame_data = fr;
    @(posedge clk);
    for (int t = 0; t <= tend; t++) begin
      @(negedge clk);
      frame_valid = 1'b0;
      check({tag, " out"}, pulse_out, inv ^ (aout & trig & exp_on(t, t0, p, we, ne)));
      check({tag, " irq"}, irq, airq & trig & exp_irq(t, t0, p, ne));
      if (t == second_at) frame_valid = 1'b1;
      if (t == stop_at) ext_stop = 1'b1;
      if (t == stop_at + 4) ext_stop = 1'b0;
    end
  endtask

  task automatic run_start(input string tag, input logic [1:0] sel, input int d, input int w);
    int lat;
    lat = (sel == 2'd2) ? 3 : 2;
    @(negedge clk);
    cfg_start_sel = sel; cfg_mode = 2'd0; cfg_delay = DW'(d); cfg_width = WW'(w);
    cfg_act_out = 1'b1; cfg_act_irq = 1'b0; cfg_invert = 1'b0;
    frame_valid = 1'b1; frame_data = cfg_match_word;
    @(posedge clk);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      frame_valid = 1'b0;
      check({tag, " armed"}, pulse_out, 1'b0);
    end
    if (sel == 2'd2) ext_start = 1'b1; else chain_in = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= lat + d + w + 3; t++) begin
      @(negedge clk);
      check({tag, " out"}, pulse_out, (t >= lat + d) && (t < lat + d + w));
      if (t == 3) begin ext_start = 1'b0; chain_in = 1'b0; end
    end
    @(negedge clk);
    cfg_start_sel = 2'd0;
  endtask

  task automatic run_clk(input string tag, input logic [1:0] sel, input int d);
    @(negedge clk);
    cfg_clk_sel = sel; cfg_mode = 2'd0; cfg_delay = DW'(d); cfg_width = 3'd4;
    cfg_act_out = 1'b1; cfg_invert = 1'b0;
    frame_valid = 1'b1; frame_data = cfg_match_word;
    @(posedge clk);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      frame_valid = 1'b0;
      check({tag, " wait"}, pulse_out, 1'b0);
    end
    for (int i = 0; i <= d; i++) begin
      if (sel == 2'd2) ext_clk = 1'b1; else chain_in = 1'b1;
      @(posedge clk);
      @(negedge clk); @(negedge clk); @(negedge clk);
      check({tag, " tick"}, pulse_out, (i == d));
      ext_clk = 1'b0; chain_in = 1'b0;
      @(negedge clk); @(negedge clk);
    end
    for (int t = 0; t < 10; t++) @(negedge clk);
    check({tag, " done"}, pulse_out, 1'b0);
    cfg_clk_sel = 2'd0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 out", pulse_out, 1'b0);
    check("R12 irq", irq, 1'b0);
    check("R12 ovr", overrun, 1'b0);

    // R2 R3 R4 R5 once sweep, width 0 included
    for (int d = 0; d < 6; d++)
      for (int w = 0; w < 4; w++)
        run_evt("R2 R3 R4 R5 once", d, w, 1, 2'd0, 1, 1, 0, 32'h1234_5678, 1, 0, -1, -1);
    // R2 largest delay
    run_evt("R2 dmax", 255, 1, 1, 2'd0, 1, 1, 0, 32'h1234_5678, 1, 0, -1, -1);
    // R6 multi sweep, count 0 treated as 1
    for (int d = 0; d < 3; d++)
      for (int w = 1; w < 4; w++)
        for (int n = 0; n < 4; n++)
          run_evt("R6 multi", d, w, n, 2'd1, 1, 1, 0, 32'h1234_5678, 1, 0, -1, -1);
    // R11 action and polarity combinations
    for (int a = 0; a < 8; a++)
      run_evt("R11 action", 1, 2, 2, 2'd1, a[0], a[1], a[2], 32'h1234_5678, 1, 0, -1, -1);
    // R7 stop ignored outside burst
    run_evt("R7 stop ignored", 2, 2, 3, 2'd1, 1, 1, 0, 32'h1234_5678, 1, 0, -1, 3);
    // R1 mask behaviour
    cfg_match_mask = 32'hFFFF_0000;
    run_evt("R1 masked bits", 1, 1, 1, 2'd0, 1, 1, 0, 32'h1234_ABCD, 1, 0, -1, -1);
    run_evt("R1 compared bit", 1, 1, 1, 2'd0, 1, 1, 0, 32'h1235_5678, 0, 0, -1, -1);
    cfg_match_mask = 32'h0;
    run_evt("R1 wildcard", 0, 2, 1, 2'd0, 1, 1, 0, 32'hDEAD_BEEF, 1, 0, -1, -1);
    cfg_match_mask = 32'hFFFF_FFFF;
    run_evt("R1 exact miss", 1, 1, 1, 2'd0, 1, 1, 0, 32'h1234_5679, 0, 0, -1, -1);
    cfg_enable = 1'b0;
    run_evt("R1 disabled", 1, 1, 1, 2'd0, 1, 1, 0, 32'h1234_5678, 0, 0, -1, -1);
    cfg_enable = 1'b1;
    // R8 start sources
    run_start("R8 chain start", 2'd1, 0, 2);
    run_start("R8 chain start", 2'd1, 3, 1);
    run_start("R8 ext start", 2'd2, 0, 1);
    run_start("R8 ext start", 2'd2, 2, 3);
    // R9 clock sources
    run_clk("R9 chain clk", 2'd1, 0);
    run_clk("R9 chain clk", 2'd1, 2);
    run_clk("R9 ext clk", 2'd2, 0);
    run_clk("R9 ext clk", 2'd2, 3);
    // R7 burst: runs freely, then stops after an ext_stop edge
    run_evt("R7 burst", 2, 1, 0, 2'd2, 1, 1, 0, 32'h1234_5678, 1, 20, -1, -1);
    @(negedge clk) ext_stop = 1'b1;
    repeat (4) @(negedge clk);
    ext_stop = 1'b0;
    repeat (15) @(negedge clk);
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      check("R7 burst stopped", pulse_out, 1'b0);
    end
    // R10 hit while busy is ignored and flagged
    check("R10 clear before", overrun, 1'b0);
    run_evt("R10 busy hit", 10, 2, 1, 2'd0, 1, 1, 0, 32'h1234_5678, 1, 0, 3, -1);
    check("R10 flag set", overrun, 1'b1);
    run_evt("R10 next hit", 1, 1, 1, 2'd0, 1, 1, 0, 32'h1234_5678, 1, 0, -1, -1);
    check("R10 flag sticky", overrun, 1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule